// File: doc/BRIEF.md
# Dynamic Doubleword Funnel Shifter

This unit executes the two dynamic doubleword shift operations of a 64-bit core: shift left and shift right by an amount taken from a register. Unlike a plain shifter, the vacated bit positions are filled from a third operand rather than with zeros. The bits pushed out of the source are returned as a separate word, and an overflow flag reports whether any of them was nonzero. Feeding one operation's shifted-out word into the next one's fill operand chains shifts across multiword values.

Each accepted operation is registered and presented one clock after it is issued. When the record bit is set, the unit also produces a 4-bit condition field and its write enable. The field holds a signed comparison of the result against zero and a copy of the summary-overflow input.

Top module: `dsh_unit`

Bit 63 is the most significant bit throughout. n denotes `amt_b_i[5:0]`.

## Requirements
- R1: The shift amount n is `amt_b_i[5:0]`; bits 63..6 of `amt_b_i` have no effect on any output.
- R2: With `dir_right_i`=0 (left), `result_o` = `src_a_i` shifted left by n, and its low n bits equal the low n bits of `fill_c_i`.
- R3: With `dir_right_i`=1 (right), `result_o` = `src_a_i` shifted right by n, and its top n bits equal the top n bits of `fill_c_i`.
- R4: On a left shift, `spill_o` carries the top n bits of `src_a_i` in its low n bits; all its other bits are 0.
- R5: On a right shift, `spill_o` carries the low n bits of `src_a_i` in its top n bits; all its other bits are 0.
- R6: `ovf_o` is 1 exactly when `spill_o` is nonzero for that operation; it is cleared by every new operation.
- R7: With n=0, in either direction, `result_o` equals `src_a_i`, `spill_o` is 0 and `ovf_o` is 0.
- R8: `cr_we_o` equals the record bit `rec_i` of the operation. When it is 1, `cr_o` = {LT, GT, EQ, SO} at bits 3..0. LT, GT and EQ come from a signed comparison of `result_o` with zero, and SO is `so_i`. When it is 0, `cr_o` is 0.
- R9: `out_valid_o` is `in_valid_i` delayed by one clock. Outputs take new values only for an operation with `in_valid_i`=1 and otherwise hold.
- R10: While `rst_ni` is low, `out_valid_o`, `result_o`, `spill_o`, `ovf_o`, `cr_o` and `cr_we_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation issue strobe |
| dir_right_i | input | 1 | 0 = shift left, 1 = shift right |
| rec_i | input | 1 | Record bit: write the condition field |
| src_a_i | input | 64 | Source word A |
| amt_b_i | input | 64 | Shift amount operand B (low 6 bits used) |
| fill_c_i | input | 64 | Fill operand C |
| so_i | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64 | Shifted result |
| spill_o | output | 64 | Shifted-out bits |
| ovf_o | output | 1 | Shifted-out bits nonzero |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr_we_o | output | 1 | Condition field write enable |

## Verification
The bench targets n=0 in both directions. A rotator that treats a right shift by zero as a rotate by 64 without wrapping would emit zero or a fill-polluted result there, and would raise a false overflow. It drives n=1 and n=63 with all-ones and all-zeros fill, where an off-by-one mask steals or leaks one fill bit and moves the spill word by one position. It also sets the upper bits of B and drives negative, zero and positive results with the record bit on and off. These cases catch a design that decodes too many amount bits, compares unsigned, or writes the condition field unconditionally.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
  localparam int unsigned XLEN_DEF = 64;
  localparam int unsigned CR_W     = 4;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } dir_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/dsh_rotl.sv
module dsh_rotl #(
  parameter int unsigned W  = 64,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  rot_o
);
  logic [W-1:0] stage [AW+1];

  assign stage[0] = data_i;

  // log-depth barrel: stage s rotates by 2**s
  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][W-1-SH:0], stage[s][W-1:W-SH]}
                                 : stage[s];
  end

  assign rot_o = stage[AW];
endmodule

// File: rtl/dsh_mask.sv
module dsh_mask #(
  parameter int unsigned W  = 64,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  low_o,
  output logic [W-1:0]  high_o
);
  // low_o: ones in the n least significant bits
  for (genvar i = 0; i < W; i++) begin : g_low
    assign low_o[i] = ({1'b0, amt_i} > (AW+1)'(i));
  end

  // high_o: ones in the n most significant bits
  for (genvar i = 0; i < W; i++) begin : g_high
    assign high_o[i] = low_o[W-1-i];
  end
endmodule

// File: rtl/dsh_core.sv
module dsh_core
  import dsh_pkg::*;
#(
  parameter int unsigned W  = 64,
  localparam int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  src_a_i,
  input  logic [AW-1:0] amt_i,
  input  logic [W-1:0]  fill_c_i,
  input  dir_e          dir_i,
  output logic [W-1:0]  result_o,
  output logic [W-1:0]  spill_o,
  output logic          ovf_o
);
  logic [AW-1:0] rot_amt;
  logic [W-1:0]  rot;
  logic [W-1:0]  low_m;
  logic [W-1:0]  high_m;
  logic [W-1:0]  fill_m;

  // right shift by n == left rotate by (W - n) mod W
  assign rot_amt = (dir_i == DIR_RIGHT) ? (AW'(0) - amt_i) : amt_i;

  dsh_rotl #(.W(W)) u_rotl (
    .data_i (src_a_i),
    .amt_i  (rot_amt),
    .rot_o  (rot)
  );

  dsh_mask #(.W(W)) u_mask (
    .amt_i  (amt_i),
    .low_o  (low_m),
    .high_o (high_m)
  );

  assign fill_m   = (dir_i == DIR_RIGHT) ? high_m : low_m;
  assign result_o = (rot & ~fill_m) | (fill_c_i & fill_m);
  assign spill_o  = rot & fill_m;
  assign ovf_o    = |spill_o;
endmodule

// File: rtl/dsh_cond.sv
module dsh_cond
  import dsh_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] result_i,
  input  logic         rec_i,
  input  logic         so_i,
  output cond_t        cr_o,
  output logic         cr_we_o
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (result_i == '0);
  assign is_neg  = result_i[W-1];

  always_comb begin
    cr_o = '0;
    if (rec_i) begin
      cr_o.lt = is_neg;
      cr_o.gt = !is_neg && !is_zero;
      cr_o.eq = is_zero;
      cr_o.so = so_i;
    end
  end

  assign cr_we_o = rec_i;
endmodule

// File: rtl/dsh_unit.sv
module dsh_unit
  import dsh_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_DEF,
  localparam int unsigned AW  = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic            dir_right_i,
  input  logic            rec_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] amt_b_i,
  input  logic [XLEN-1:0] fill_c_i,
  input  logic            so_i,
  output logic            out_valid_o,
  output logic [XLEN-1:0] result_o,
  output logic [XLEN-1:0] spill_o,
  output logic            ovf_o,
  output logic [CR_W-1:0] cr_o,
  output logic            cr_we_o
);
  logic [AW-1:0]   amt;
  logic [XLEN-1:0] res_d;
  logic [XLEN-1:0] spill_d;
  logic            ovf_d;
  cond_t           cr_d;
  logic            cr_we_d;
  dir_e            dir;
  logic            unused_amt_hi;

  assign amt           = amt_b_i[AW-1:0];
  assign unused_amt_hi = ^amt_b_i[XLEN-1:AW];
  assign dir           = dir_right_i ? DIR_RIGHT : DIR_LEFT;

  dsh_core #(.W(XLEN)) u_core (
    .src_a_i  (src_a_i),
    .amt_i    (amt),
    .fill_c_i (fill_c_i),
    .dir_i    (dir),
    .result_o (res_d),
    .spill_o  (spill_d),
    .ovf_o    (ovf_d)
  );

  dsh_cond #(.W(XLEN)) u_cond (
    .result_i (res_d),
    .rec_i    (rec_i),
    .so_i     (so_i),
    .cr_o     (cr_d),
    .cr_we_o  (cr_we_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      spill_o  <= '0;
      ovf_o    <= 1'b0;
      cr_o     <= '0;
      cr_we_o  <= 1'b0;
    end else if (in_valid_i) begin
      result_o <= res_d;
      spill_o  <= spill_d;
      ovf_o    <= ovf_d;
      cr_o     <= cr_d;
      cr_we_o  <= cr_we_d;
    end
  end
endmodule

// File: rtl/dsh_unit_chk.sv
module dsh_unit_chk
  import dsh_pkg::*;
#(
  parameter int unsigned XLEN = XLEN_DEF,
  localparam int unsigned AW  = $clog2(XLEN)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            dir_right_i,
  input logic            rec_i,
  input logic [XLEN-1:0] src_a_i,
  input logic [XLEN-1:0] amt_b_i,
  input logic [XLEN-1:0] fill_c_i,
  input logic            so_i,
  input logic            out_valid_o,
  input logic [XLEN-1:0] result_o,
  input logic [XLEN-1:0] spill_o,
  input logic            ovf_o,
  input logic [CR_W-1:0] cr_o,
  input logic            cr_we_o
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R9
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o) && $stable(spill_o) && $stable(cr_o)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_o == '0) |-> !ovf_o); // R6
  AST_OVERFLOW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_o != '0) |-> ovf_o); // R6
  AST_ZERO_AMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && amt_b_i[AW-1:0] == '0) |=>
      (result_o == $past(src_a_i)) && (spill_o == '0)); // R7
  AST_CR_WE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && rec_i) |=> cr_we_o && (cr_o[0] == $past(so_i))); // R8
  AST_CR_WE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !rec_i) |=> !cr_we_o && (cr_o == '0)); // R8
  AST_CR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> ($countones(cr_o[3:1]) == 1)); // R8
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !out_valid_o && !ovf_o && !cr_we_o); // R10
endmodule

bind dsh_unit dsh_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_dsh_unit.sv
module tb_dsh_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        dir_right_i = 1'b0;
  logic        rec_i = 1'b0;
  logic [63:0] src_a_i = '0;
  logic [63:0] amt_b_i = '0;
  logic [63:0] fill_c_i = '0;
  logic        so_i = 1'b0;
  logic        out_valid_o;
  logic [63:0] result_o;
  logic [63:0] spill_o;
  logic        ovf_o;
  logic [3:0]  cr_o;
  logic        cr_we_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk_i = ~clk_i;

  dsh_unit dut (.*);

  // expected values of the most recent issued operation
  logic [63:0] e_res, e_spill;
  logic        e_ovf, e_we;
  logic [3:0]  e_cr;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(logic d, logic r, logic [63:0] a, logic [63:0] b,
                       logic [63:0] c, logic so);
    int n;
    n = int'(b[5:0]);
    if (n == 0) begin
      e_res = a; e_spill = '0;
    end else if (!d) begin
      e_res   = (a << n) | (c & ((64'd1 << n) - 64'd1));
      e_spill = a >> (64 - n);
    end else begin
      e_res   = (a >> n) | (c & ~({64{1'b1}} >> n));
      e_spill = a << (64 - n);
    end
    e_ovf = (e_spill != 0);
    e_we  = r;
    if (r) e_cr = {$signed(e_res) < 0, $signed(e_res) > 0, e_res == 0, so};
    else   e_cr = 4'd0;
  endtask

  // drive at negedge, check at following negedge (one register stage)
  task automatic op(string req, logic d, logic r, logic [63:0] a, logic [63:0] b,
                    logic [63:0] c, logic so);
    in_valid_i = 1'b1; dir_right_i = d; rec_i = r;
    src_a_i = a; amt_b_i = b; fill_c_i = c; so_i = so;
    model(d, r, a, b, c, so);
    @(negedge clk_i);
    chk(req, "valid",  {63'd0, out_valid_o}, 64'd1);
    chk(req, "result", result_o, e_res);
    chk(req, "spill",  spill_o, e_spill);
    chk(req, "ovf",    {63'd0, ovf_o}, {63'd0, e_ovf});
    chk(req, "cr",     {60'd0, cr_o}, {60'd0, e_cr});
    chk(req, "cr_we",  {63'd0, cr_we_o}, {63'd0, e_we});
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    in_valid_i = 1'b1;
    src_a_i = 64'hDEAD_BEEF_0123_4567;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10", "valid",  {63'd0, out_valid_o}, 64'd0);
    chk("R10", "result", result_o, 64'd0);
    chk("R10", "spill",  spill_o, 64'd0);
    chk("R10", "cr",     {60'd0, cr_o, cr_we_o, ovf_o}, 64'd0);
    in_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7 zero amount, both directions, fills that would pollute
    op("R7", 1'b0, 1'b0, 64'h8123_4567_89AB_CDEF, 64'd0, '1, 1'b0);
    op("R7", 1'b1, 1'b0, 64'h8123_4567_89AB_CDEF, 64'd0, '1, 1'b0);
    op("R7", 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h40, 64'd0, 1'b0);

    // R2 R4 left boundaries
    op("R2", 1'b0, 1'b0, 64'h8000_0000_0000_0001, 64'd1, '1, 1'b0);
    op("R4", 1'b0, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b0);
    op("R2", 1'b0, 1'b0, 64'hC000_0000_0000_0003, 64'd63, '0, 1'b0);
    op("R4", 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd63, '1, 1'b0);
    // R3 R5 right boundaries
    op("R3", 1'b1, 1'b0, 64'h8000_0000_0000_0001, 64'd1, '1, 1'b0);
    op("R5", 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1, '0, 1'b0);
    op("R3", 1'b1, 1'b0, 64'hC000_0000_0000_0003, 64'd63, '0, 1'b0);
    op("R5", 1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd63, '1, 1'b0);
    // R6 overflow clears after a set
    op("R6", 1'b0, 1'b0, 64'hF000_0000_0000_0000, 64'd4, '0, 1'b0);
    op("R6", 1'b0, 1'b0, 64'h0FFF_FFFF_FFFF_FFFF, 64'd4, '0, 1'b0);

    // R1 upper amount bits ignored
    op("R1", 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFC5, '0, 1'b0);
    op("R1", 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hA5A5_A5A5_A5A5_A580, '1, 1'b0);

    // R8 condition field
    op("R8", 1'b0, 1'b1, 64'h4000_0000_0000_0000, 64'd1, '0, 1'b0);  // negative
    op("R8", 1'b1, 1'b1, 64'h0000_0000_0000_0001, 64'd1, '0, 1'b1);  // zero
    op("R8", 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd1, '0, 1'b1);  // positive
    op("R8", 1'b0, 1'b0, 64'h4000_0000_0000_0000, 64'd1, '0, 1'b1);  // no record

    // R9 idle cycle: outputs hold, valid drops
    in_valid_i = 1'b0; src_a_i = rnd64(); amt_b_i = 64'd7; rec_i = 1'b1;
    @(negedge clk_i);
    chk("R9", "valid",  {63'd0, out_valid_o}, 64'd0);
    chk("R9", "result", result_o, e_res);
    chk("R9", "cr",     {60'd0, cr_o}, {60'd0, e_cr});

    // random sweep, R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 400; i++) begin
      logic [63:0] fc;
      case (i % 3)
        0: fc = '0;
        1: fc = '1;
        default: fc = rnd64();
      endcase
      op(($urandom() & 1) ? "R2R4" : "R3R5", 1'($urandom()), 1'($urandom()),
         rnd64(), rnd64(), fc, 1'($urandom()));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule